// File: doc/BRIEF.md
# UART Receive Bulk-IN Forwarding Controller

This block decides when bytes sitting in a UART receive FIFO may be handed to a USB bulk IN endpoint. It looks at the FIFO fill count, a pulse for each arriving byte, a character-time tick from the baud generator and a pulse for each bulk IN request from the host. One cycle after each request it answers with either a grant carrying the packet length or a NAK.

In normal mode, data is held back until a full packet is waiting. It is also released once the line has been idle for three character times while the FIFO holds data. In low-latency mode, every request flushes whatever is present. A single grant never exceeds the maximum packet size, which is 64 bytes or, when shortened, 63 bytes. The block also holds two small configuration registers. One selects the packet size and is set automatically by a class-command strobe. The other holds the low-latency bit, which is forced on while the programmed baud rate is below the speed threshold.

Top module: `rx_release_ctrl`

## Requirements
- R1: After reset, grant_valid and nak are 0, both configuration registers read 0x00, the packet size is 64 and low latency is off.
- R2: Configuration address 0 holds the short-packet bit in bit 0, and address 1 holds the low-latency bit in bit 0. Bits 7:1 of both read as 0 and ignore writes. cfg_rdata shows the addressed register combinationally.
- R3: A pulse on acm_cmd sets the short-packet bit to 1. From then on the maximum packet size is 63.
- R4: In normal mode, a request with 0 < fifo_count < max packet size and no idle timeout is answered with nak.
- R5: In normal mode, a request with fifo_count >= max packet size (64, or 63 when short) is granted with a length equal to the max packet size.
- R6: When 3 char_tick pulses have passed with no byte_rx, a request with fifo_count > 0 is granted min(fifo_count, max packet size). After only 2 such ticks, the request gets nak.
- R7: byte_rx restarts the idle count. When byte_rx and char_tick arrive in the same cycle, the byte wins and that tick is not counted.
- R8: A grant clears the idle count, so leftover bytes below a full packet wait for a fresh 3-tick timeout.
- R9: In low-latency mode, any request with fifo_count > 0 is granted min(fifo_count, max packet size).
- R10: A request with fifo_count = 0 is always answered with nak, in every mode.
- R11: A pulse on div_we while baud_slow = 1 forces the effective low-latency bit to 1, and address 1 reads 0x01 even if software writes it with 0. A later pulse on div_we with baud_slow = 0 returns control to the bit written by software.
- R12: grant_valid or nak is a single-cycle pulse in the cycle after bulk_req. Exactly one of them is raised per request, and neither is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Configuration register select: 0 = packet size, 1 = low latency |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| acm_cmd | input | 1 | Class-command seen strobe, sets the short-packet bit |
| div_we | input | 1 | Baud divisor written strobe |
| baud_slow | input | 1 | Programmed baud rate is below the threshold |
| fifo_count | input | 8 | Bytes currently in the receive FIFO |
| byte_rx | input | 1 | A byte arrived this cycle |
| char_tick | input | 1 | One character time elapsed |
| bulk_req | input | 1 | Bulk IN request pulse |
| grant_valid | output | 1 | Grant pulse |
| grant_len | output | 8 | Bytes to send with the grant |
| nak | output | 1 | No eligible data for this request |

## Verification
A byte arrival and a character tick can land in the same cycle, and the idle counter must then treat the byte as the winner. The bench provokes this by giving two ticks, then a cycle with both byte_rx and char_tick high, then two more ticks. A request at that point must get a NAK, while one further tick must turn it into a full grant. Had the tick been counted, the timeout would have fired early. The same kind of overlap between a grant and the timer is judged by requesting again right after a timeout grant and expecting a NAK.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int CFG_DW = 8;
  localparam logic CFG_PKT = 1'b0;
  localparam logic CFG_LAT = 1'b1;
  localparam logic [CFG_DW-1:0] PKT_MASK = 8'h01;
  localparam logic [CFG_DW-1:0] LAT_MASK = 8'h01;
endpackage

// File: rtl/rrc_cfg.sv
module rrc_cfg
  import rrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              acm_cmd,
  input  logic              div_we,
  input  logic              baud_slow,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              short_pkt,
  output logic              low_lat
);
  logic [CFG_DW-1:0] pkt_q, lat_q;
  logic              slow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q  <= '0;
      lat_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == CFG_PKT) pkt_q <= cfg_wdata & PKT_MASK;
      if (acm_cmd) pkt_q[0] <= 1'b1;
      if (cfg_we && cfg_addr == CFG_LAT) lat_q <= cfg_wdata & LAT_MASK;
      if (div_we) slow_q <= baud_slow;
    end
  end

  assign short_pkt = pkt_q[0];
  assign low_lat   = lat_q[0] | slow_q;
  assign cfg_rdata = (cfg_addr == CFG_LAT) ? (lat_q | {{(CFG_DW-1){1'b0}}, slow_q}) : pkt_q;

  AST_ACM_SETS_SHORT: assert property (@(posedge clk) disable iff (rst)
    acm_cmd |=> short_pkt); // R3
  AST_SLOW_FORCES_LL: assert property (@(posedge clk) disable iff (rst)
    (div_we && baud_slow) |=> low_lat); // R11
endmodule

// File: rtl/rrc_idle.sv
module rrc_idle #(
  parameter int IDLE_CHARS = 3,
  localparam int TICK_W = $clog2(IDLE_CHARS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic byte_rx,
  input  logic char_tick,
  input  logic clear,
  output logic expired
);
  localparam logic [TICK_W-1:0] LIMIT = TICK_W'(IDLE_CHARS);
  logic [TICK_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || byte_rx || clear) cnt <= '0;
    else if (char_tick && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    byte_rx |=> !expired); // R7
  AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clear |=> !expired); // R8
endmodule

// File: rtl/rrc_grant.sv
module rrc_grant #(
  parameter int CNT_W   = 8,
  parameter int MAX_PKT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bulk_req,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             short_pkt,
  input  logic             low_lat,
  input  logic             expired,
  output logic             fire,
  output logic             grant_valid,
  output logic [CNT_W-1:0] grant_len,
  output logic             nak
);
  localparam logic [CNT_W-1:0] MAXP = CNT_W'(MAX_PKT);
  logic [CNT_W-1:0] max_now, len_now;
  logic             has_data, full, eligible;

  always_comb begin
    max_now  = short_pkt ? MAXP - 1'b1 : MAXP;
    has_data = (fifo_count != '0);
    full     = (fifo_count >= max_now);
    eligible = has_data && (low_lat || full || expired);
    len_now  = full ? max_now : fifo_count;
    fire     = bulk_req && eligible;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_len   <= '0;
      nak         <= 1'b0;
    end else begin
      grant_valid <= fire;
      nak         <= bulk_req && !eligible;
      if (fire) grant_len <= len_now;
    end
  end

  AST_GRANT_NAK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && nak)); // R12
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    bulk_req |=> (grant_valid || nak)); // R12
  AST_NO_UNSOLICITED: assert property (@(posedge clk) disable iff (rst)
    !bulk_req |=> (!grant_valid && !nak)); // R12
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (grant_len != '0 && grant_len <= MAXP)); // R9
  AST_EMPTY_NAK: assert property (@(posedge clk) disable iff (rst)
    (bulk_req && fifo_count == '0) |=> nak); // R10
endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl
  import rrc_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int MAX_PKT    = 64,
  parameter int IDLE_CHARS = 3,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              acm_cmd,
  input  logic              div_we,
  input  logic              baud_slow,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              byte_rx,
  input  logic              char_tick,
  input  logic              bulk_req,
  output logic              grant_valid,
  output logic [CNT_W-1:0]  grant_len,
  output logic              nak
);
  logic short_pkt, low_lat, expired, fire;

  rrc_cfg u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acm_cmd(acm_cmd), .div_we(div_we),
    .baud_slow(baud_slow), .cfg_rdata(cfg_rdata),
    .short_pkt(short_pkt), .low_lat(low_lat)
  );

  rrc_idle #(.IDLE_CHARS(IDLE_CHARS)) u_idle (
    .clk(clk), .rst(rst), .byte_rx(byte_rx), .char_tick(char_tick),
    .clear(fire), .expired(expired)
  );

  rrc_grant #(.CNT_W(CNT_W), .MAX_PKT(MAX_PKT)) u_grant (
    .clk(clk), .rst(rst), .bulk_req(bulk_req), .fifo_count(fifo_count),
    .short_pkt(short_pkt), .low_lat(low_lat), .expired(expired),
    .fire(fire), .grant_valid(grant_valid), .grant_len(grant_len), .nak(nak)
  );
endmodule

// File: tb/tb_rx_release_ctrl.sv
`timescale 1ns/1ps
module tb_rx_release_ctrl;
  logic clk = 0, rst = 1;
  logic cfg_we = 0, cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic acm_cmd = 0, div_we = 0, baud_slow = 0;
  logic [7:0] fifo_count = 0;
  logic byte_rx = 0, char_tick = 0, bulk_req = 0;
  logic grant_valid, nak;
  logic [7:0] grant_len;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rx_release_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acm_cmd(acm_cmd),
    .div_we(div_we), .baud_slow(baud_slow), .fifo_count(fifo_count),
    .byte_rx(byte_rx), .char_tick(char_tick), .bulk_req(bulk_req),
    .grant_valid(grant_valid), .grant_len(grant_len), .nak(nak)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(logic a, logic [7:0] exp, string tag);
    @(negedge clk); cfg_addr = a; #1;
    chk(tag, {8'h0, cfg_rdata}, {8'h0, exp});
  endtask

  task automatic byte_in();
    @(negedge clk); byte_rx = 1; @(negedge clk); byte_rx = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1; @(negedge clk); char_tick = 0;
    end
  endtask

  // exp_g=1 expects grant of exp_len, else nak; also checks the pulse width (R12)
  task automatic req(logic exp_g, logic [7:0] exp_len, string tag);
    @(negedge clk); bulk_req = 1;
    @(negedge clk); bulk_req = 0;
    chk({tag, " grant"}, {15'h0, grant_valid}, {15'h0, exp_g});
    chk({tag, " nak"}, {15'h0, nak}, {15'h0, !exp_g});
    if (exp_g) chk({tag, " len"}, {8'h0, grant_len}, {8'h0, exp_len});
    @(negedge clk);
    chk({tag, " R12 pulse"}, {14'h0, grant_valid, nak}, 16'h0);
  endtask

  task automatic t_reset();
    chk("R1 grant", {15'h0, grant_valid}, 16'h0);
    chk("R1 nak", {15'h0, nak}, 16'h0);
    cfg_read(1'b0, 8'h00, "R1 pkt reg");
    cfg_read(1'b1, 8'h00, "R1 lat reg");
  endtask

  task automatic t_cfg();
    cfg_write(1'b0, 8'hFF); cfg_read(1'b0, 8'h01, "R2 pkt ff");
    cfg_write(1'b0, 8'hFE); cfg_read(1'b0, 8'h00, "R2 pkt fe");
    cfg_write(1'b1, 8'hFF); cfg_read(1'b1, 8'h01, "R2 lat ff");
    cfg_write(1'b1, 8'hFE); cfg_read(1'b1, 8'h00, "R2 lat fe");
  endtask

  task automatic t_normal();
    fifo_count = 8'd10; byte_in();
    req(1'b0, 8'd0, "R4 partial");
    fifo_count = 8'd64; req(1'b1, 8'd64, "R5 full64");
    fifo_count = 8'd100; req(1'b1, 8'd64, "R5 over64");
    cfg_write(1'b0, 8'h01);
    fifo_count = 8'd63; req(1'b1, 8'd63, "R5 full63");
    byte_in();
    fifo_count = 8'd62; req(1'b0, 8'd0, "R5 short 62 nak");
    cfg_write(1'b0, 8'h00);
  endtask

  task automatic t_timeout();
    fifo_count = 8'd5; byte_in();
    ticks(2); req(1'b0, 8'd0, "R6 two ticks");
    ticks(1); req(1'b1, 8'd5, "R6 three ticks");
    req(1'b0, 8'd0, "R8 after grant");
    ticks(3); req(1'b1, 8'd5, "R8 fresh timeout");
  endtask

  task automatic t_restart();
    fifo_count = 8'd7; byte_in();
    ticks(2); byte_in(); ticks(2);
    req(1'b0, 8'd0, "R7 restart");
    byte_in(); ticks(2);
    @(negedge clk); byte_rx = 1; char_tick = 1;
    @(negedge clk); byte_rx = 0; char_tick = 0;
    ticks(2); req(1'b0, 8'd0, "R7 same cycle");
    ticks(1); req(1'b1, 8'd7, "R7 after third");
  endtask

  task automatic t_lowlat();
    cfg_write(1'b1, 8'h01);
    fifo_count = 8'd1; byte_in(); req(1'b1, 8'd1, "R9 one byte");
    fifo_count = 8'd100; req(1'b1, 8'd64, "R9 capped");
    fifo_count = 8'd0; req(1'b0, 8'd0, "R10 empty ll");
    cfg_write(1'b1, 8'h00);
    ticks(3); req(1'b0, 8'd0, "R10 empty timeout");
  endtask

  task automatic t_slow();
    @(negedge clk); baud_slow = 1; div_we = 1; @(negedge clk); div_we = 0;
    cfg_read(1'b1, 8'h01, "R11 forced");
    cfg_write(1'b1, 8'h00); cfg_read(1'b1, 8'h01, "R11 write0 held");
    fifo_count = 8'd2; byte_in(); req(1'b1, 8'd2, "R11 ll grant");
    @(negedge clk); baud_slow = 0; div_we = 1; @(negedge clk); div_we = 0;
    cfg_read(1'b1, 8'h00, "R11 released");
    byte_in(); req(1'b0, 8'd0, "R11 normal again");
  endtask

  task automatic t_acm();
    @(negedge clk); acm_cmd = 1; @(negedge clk); acm_cmd = 0;
    cfg_read(1'b0, 8'h01, "R3 auto short");
    fifo_count = 8'd63; req(1'b1, 8'd63, "R3 grant 63");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_cfg();
    t_normal();
    t_timeout();
    t_restart();
    t_lowlat();
    t_slow();
    t_acm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule